// File: doc/BRIEF.md
# UART Interrupt and Line-Status Controller

This block is the register-side status and interrupt unit of a 16550-compatible UART. A host reaches it through a byte-wide register port with a 3-bit address and single-cycle read and write strobes. It holds the line control, interrupt enable and divisor latch registers and the FIFO-enable bit. It keeps the line status bits and drives one interrupt request. It also reports the highest-priority pending source through the identification register.

The serial shifters, the FIFO storage, the baud generator and the modem logic sit outside. They report to this block through level and pulse inputs: data ready, holding-empty and shifter-empty events, overrun, parity, framing and break events, and an error-in-FIFO event. The block tells the transmit path when a byte has been written with `tx_load` and `tx_byte`. It tells the receive path when the receive buffer has been read with `rx_pop`. It presents the divisor and line settings as outputs.

Top module: `uart_intr_ctrl`

## Requirements
- R1: While line control bit 7 is set, a write or read at address 0 reaches the divisor low latch and one at address 1 reaches the divisor high latch. No transmit load or IER change takes place. `divisor` shows {high, low}.
- R2: After reset the line status register (address 5) reads 0x60, with bit 5 holding-empty and bit 6 transmitter-empty set. A write to address 0 with bit 7 of the line control register clear pulses `tx_load` with `tx_byte` equal to the written byte. It clears bits 5 and 6, so the register then reads 0x00 when nothing else is set. A holding-empty event sets bit 5 again, and a shifter-empty event sets bit 6 again.
- R3: After reset `irq` is low. Writing the interrupt enable register (address 1) with bit 1 set while the holding register is empty raises `irq`.
- R4: The identification register (address 2) reads {F, F, 0, 0, code}. F is bit 0 of the last write to address 2. The code is 0110 for line status, 0100 for received data, 0010 for holding-empty and 0001 for none pending, and the sources rank in that order.
- R5: Line status bits 1 to 4 are overrun, parity, framing and break, and bit 7 is error-in-FIFO. Each is set by its event pulse and stays set until the line status register is read. That read clears all five together and leaves bit 0, which follows `rx_ready`.
- R6: Enable bit 2 gates the line-status source, bit 0 gates received data and bit 1 gates holding-empty. Clearing the bit of the only pending source drops `irq`, and setting it again raises `irq`.
- R7: The holding-empty interrupt is cleared by reading the identification register while it is the reported source, or by a transmit write. A later holding-empty event re-arms it, and so does setting enable bit 1 while bit 5 is set.
- R8: Reading the identification register while a higher-priority source is reported leaves a pending holding-empty interrupt armed.
- R9: An error event in the same cycle as a line-status read leaves its bit set. A holding-empty event in the same cycle as an identification read keeps the holding-empty interrupt armed. A transmit write in the same cycle as a holding-empty event leaves bit 5 clear.
- R10: `rd_data` carries the addressed value in the cycle after a read strobe and is 0 in every other cycle. Addresses 4, 6 and 7 read 0. A read of address 0 with line control bit 7 clear returns `rx_data` and pulses `rx_pop` in the same cycle as the data.
- R11: `irq` is registered and follows the pending sources one clock later.
- R12: The line control register (address 3) reads back as written, and `line_cfg` shows its bits 6 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| rd_data | output | 8 | Read data, cycle after strobe |
| rx_data | input | 8 | Byte at the head of the receive path |
| rx_ready | input | 1 | Receive data available (level) |
| ev_hold_empty | input | 1 | Holding register became empty (pulse) |
| ev_shift_empty | input | 1 | Transmit shifter became empty (pulse) |
| ev_overrun | input | 1 | Overrun event (pulse) |
| ev_parity | input | 1 | Parity error event (pulse) |
| ev_framing | input | 1 | Framing error event (pulse) |
| ev_break | input | 1 | Break event (pulse) |
| ev_fifo_err | input | 1 | Error present in receive FIFO (pulse) |
| irq | output | 1 | Interrupt request |
| tx_load | output | 1 | Byte written to transmit holding (pulse) |
| tx_byte | output | 8 | Last byte written for transmission |
| rx_pop | output | 1 | Receive buffer was read (pulse) |
| divisor | output | 16 | Divisor latch {high, low} |
| line_cfg | output | 7 | Line control bits 6..0 |

## Verification
Two actions can fall in the same clock: a host access that clears a status and an event that sets the same status. The bench provokes this on purpose. It raises a parity event in the same cycle as a line-status read, and a holding-empty event in the same cycle as an identification read that reports holding-empty. It also lands a transmit write on the same edge as a holding-empty event. The bench judges each case by what a following read returns, where the setting event must win for the status bits and the write must win for holding-empty. A behavioural model, compared on every clock, checks that `irq` follows the result one cycle later.

// File: rtl/uic_pkg.sv
`timescale 1ns/1ps
package uic_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_IER  = 3'd1;
  localparam logic [2:0] A_IIR  = 3'd2;
  localparam logic [2:0] A_LCR  = 3'd3;
  localparam logic [2:0] A_LSR  = 3'd5;

  localparam int LSR_DR   = 0;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
  localparam int LSR_FERR = 7;
  localparam int ERR_N    = 4;   // overrun, parity, framing, break

  localparam int IE_RXD  = 0;
  localparam int IE_THRE = 1;
  localparam int IE_LINE = 2;

  typedef enum logic [3:0] {
    SRC_NONE = 4'b0001,
    SRC_THRE = 4'b0010,
    SRC_RXD  = 4'b0100,
    SRC_LINE = 4'b0110
  } src_code_e;
endpackage

// File: rtl/uic_regfile.sv
`timescale 1ns/1ps
module uic_regfile
  import uic_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int IER_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              thre_lvl,
  output logic [IER_W-1:0]  ier,
  output logic [DATA_W-1:0] lcr,
  output logic              fifo_on,
  output logic [DATA_W-1:0] div_lo,
  output logic [DATA_W-1:0] div_hi,
  output logic              thr_wr,
  output logic              thre_arm
);
  logic dlab;
  logic wr_data, wr_ier, wr_fcr, wr_lcr;

  assign dlab    = lcr[DATA_W-1];
  assign wr_data = wr && (addr == A_DATA);
  assign wr_ier  = wr && (addr == A_IER);
  assign wr_fcr  = wr && (addr == A_IIR);
  assign wr_lcr  = wr && (addr == A_LCR);
  assign thr_wr  = wr_data && !dlab;

  // enabling the holding-empty source while empty re-arms it
  assign thre_arm = wr_ier && !dlab && wdata[IE_THRE] && !ier[IE_THRE] && thre_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ier     <= '0;
      lcr     <= '0;
      fifo_on <= 1'b0;
      div_lo  <= '0;
      div_hi  <= '0;
    end else begin
      if (wr_lcr) lcr <= wdata;
      if (wr_fcr) fifo_on <= wdata[0];
      if (wr_data && dlab) div_lo <= wdata;
      if (wr_ier && dlab) div_hi <= wdata;
      if (wr_ier && !dlab) ier <= wdata[IER_W-1:0];
    end
  end

  // R1
  dlab_no_ier_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ier && dlab) |=> $stable(ier));
endmodule

// File: rtl/uic_line_status.sv
`timescale 1ns/1ps
module uic_line_status
  import uic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_wr,
  input  logic              hold_ev,
  input  logic              shift_ev,
  input  logic              rx_ready,
  input  logic [ERR_N-1:0]  err_ev,
  input  logic              fifo_err_ev,
  input  logic              lsr_rd,
  output logic [DATA_W-1:0] lsr
);
  logic [ERR_N-1:0] err_q;
  logic             ferr_q;
  logic             thre_q;
  logic             temt_q;

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst)            err_q[i] <= 1'b0;
      else if (err_ev[i]) err_q[i] <= 1'b1;
      else if (lsr_rd)    err_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ferr_q <= 1'b0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
    end else begin
      if (fifo_err_ev) ferr_q <= 1'b1;
      else if (lsr_rd) ferr_q <= 1'b0;
      if (thr_wr)       thre_q <= 1'b0;
      else if (hold_ev) thre_q <= 1'b1;
      if (thr_wr)        temt_q <= 1'b0;
      else if (shift_ev) temt_q <= 1'b1;
    end
  end

  always_comb begin
    lsr = '0;
    lsr[LSR_DR]             = rx_ready;
    lsr[LSR_DR+1 +: ERR_N]  = err_q;
    lsr[LSR_THRE]           = thre_q;
    lsr[LSR_TEMT]           = temt_q;
    lsr[LSR_FERR]           = ferr_q;
  end

  // R5
  clr_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !(|err_ev) && !fifo_err_ev) |=> (lsr[LSR_DR+1 +: ERR_N] == '0 && !lsr[LSR_FERR]));
  // R9
  set_beats_read_chk: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && err_ev[1]) |=> lsr[LSR_DR+2]);
  // R2
  thr_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> (!lsr[LSR_THRE] && !lsr[LSR_TEMT]));
endmodule

// File: rtl/uic_irq_arb.sv
`timescale 1ns/1ps
module uic_irq_arb
  import uic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        ier_src,
  input  logic              line_err,
  input  logic              rx_ready,
  input  logic              thre_lvl,
  input  logic              hold_ev,
  input  logic              thr_wr,
  input  logic              thre_arm,
  input  logic              iir_rd,
  input  logic              fifo_on,
  output logic [DATA_W-1:0] iir,
  output logic              irq
);
  logic      tflag;
  logic      pend_ls, pend_rx, pend_th;
  logic      g_ls, g_rx, g_th;
  src_code_e code;

  assign pend_ls = ier_src[IE_LINE] && line_err;
  assign pend_rx = ier_src[IE_RXD]  && rx_ready;
  assign pend_th = ier_src[IE_THRE] && tflag;

  assign g_ls = pend_ls;
  assign g_rx = pend_rx && !pend_ls;
  assign g_th = pend_th && !pend_ls && !pend_rx;

  always_comb begin
    unique case (1'b1)
      g_ls:    code = SRC_LINE;
      g_rx:    code = SRC_RXD;
      g_th:    code = SRC_THRE;
      default: code = SRC_NONE;
    endcase
  end

  always_comb begin
    iir = '0;
    iir[3:0]          = code;
    iir[DATA_W-1]     = fifo_on;
    iir[DATA_W-2]     = fifo_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tflag <= 1'b1;
      irq   <= 1'b0;
    end else begin
      if (thr_wr)                             tflag <= 1'b0;
      else if (hold_ev || (thre_arm && thre_lvl)) tflag <= 1'b1;
      else if (iir_rd && g_th)                tflag <= 1'b0;
      irq <= g_ls || g_rx || g_th;
    end
  end

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({g_ls, g_rx, g_th}));
  // R6
  no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ier_src == 3'b000) |=> !irq);
  // R7
  thr_wr_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> !tflag);
  // R8
  iir_keeps_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (iir_rd && tflag && (g_ls || g_rx) && !thr_wr) |=> tflag);
endmodule

// File: rtl/uart_intr_ctrl.sv
`timescale 1ns/1ps
module uart_intr_ctrl
  import uic_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int IER_W  = 4,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  input  logic              ev_hold_empty,
  input  logic              ev_shift_empty,
  input  logic              ev_overrun,
  input  logic              ev_parity,
  input  logic              ev_framing,
  input  logic              ev_break,
  input  logic              ev_fifo_err,
  output logic              irq,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_byte,
  output logic              rx_pop,
  output logic [DIV_W-1:0]  divisor,
  output logic [DATA_W-2:0] line_cfg
);
  logic [IER_W-1:0]  ier;
  logic [DATA_W-1:0] lcr, div_lo, div_hi, lsr, iir, rmux;
  logic              fifo_on, thr_wr, thre_arm, dlab;
  logic              lsr_rd, iir_rd, rbr_rd;

  assign dlab   = lcr[DATA_W-1];
  assign lsr_rd = bus_rd && (bus_addr == A_LSR);
  assign iir_rd = bus_rd && (bus_addr == A_IIR);
  assign rbr_rd = bus_rd && (bus_addr == A_DATA) && !dlab;

  uic_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IER_W(IER_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .thre_lvl(lsr[LSR_THRE]), .ier(ier), .lcr(lcr), .fifo_on(fifo_on),
    .div_lo(div_lo), .div_hi(div_hi), .thr_wr(thr_wr), .thre_arm(thre_arm)
  );

  uic_line_status #(.DATA_W(DATA_W)) u_lsr (
    .clk(clk), .rst(rst), .thr_wr(thr_wr), .hold_ev(ev_hold_empty),
    .shift_ev(ev_shift_empty), .rx_ready(rx_ready),
    .err_ev({ev_break, ev_framing, ev_parity, ev_overrun}),
    .fifo_err_ev(ev_fifo_err), .lsr_rd(lsr_rd), .lsr(lsr)
  );

  uic_irq_arb #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst(rst), .ier_src(ier[2:0]), .line_err(|lsr[ERR_N:1]),
    .rx_ready(rx_ready), .thre_lvl(lsr[LSR_THRE]), .hold_ev(ev_hold_empty),
    .thr_wr(thr_wr), .thre_arm(thre_arm), .iir_rd(iir_rd), .fifo_on(fifo_on),
    .iir(iir), .irq(irq)
  );

  always_comb begin
    rmux = '0;
    case (bus_addr)
      A_DATA:  rmux = dlab ? div_lo : rx_data;
      A_IER:   rmux = dlab ? div_hi : {{(DATA_W-IER_W){1'b0}}, ier};
      A_IIR:   rmux = iir;
      A_LCR:   rmux = lcr;
      A_LSR:   rmux = lsr;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      tx_load <= 1'b0;
      tx_byte <= '0;
      rx_pop  <= 1'b0;
    end else begin
      rd_data <= bus_rd ? rmux : '0;
      tx_load <= thr_wr;
      rx_pop  <= rbr_rd;
      if (thr_wr) tx_byte <= bus_wdata;
    end
  end

  assign divisor  = {div_hi, div_lo};
  assign line_cfg = lcr[DATA_W-2:0];

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (rd_data == '0));
  // R1
  dlab_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DATA && dlab) |=> !tx_load);
endmodule

// File: tb/uart_intr_ctrl_bench.sv
`timescale 1ns/1ps
module uart_intr_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready = 1'b0;
  logic        ev_hold_empty = 0, ev_shift_empty = 0, ev_overrun = 0, ev_parity = 0;
  logic        ev_framing = 0, ev_break = 0, ev_fifo_err = 0;
  logic [7:0]  rd_data, tx_byte;
  logic        irq, tx_load, rx_pop;
  logic [15:0] divisor;
  logic [6:0]  line_cfg;

  always #5 clk = ~clk;

  uart_intr_ctrl u_uart_intr_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_data(rd_data), .rx_data(rx_data),
    .rx_ready(rx_ready), .ev_hold_empty(ev_hold_empty), .ev_shift_empty(ev_shift_empty),
    .ev_overrun(ev_overrun), .ev_parity(ev_parity), .ev_framing(ev_framing),
    .ev_break(ev_break), .ev_fifo_err(ev_fifo_err), .irq(irq), .tx_load(tx_load),
    .tx_byte(tx_byte), .rx_pop(rx_pop), .divisor(divisor), .line_cfg(line_cfg)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural model state
  logic [7:0] m_lcr, m_dll, m_dlm, m_rdata, m_txb;
  logic [3:0] m_ier, m_err;
  logic m_fifo, m_e7, m_thre, m_temt, m_tf, m_irq, m_txl, m_rxpop;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_lsr();
    return {m_e7, m_temt, m_thre, m_err, rx_ready};
  endfunction

  function automatic logic [3:0] m_code();
    if (m_ier[2] && (m_err != 0)) return 4'h6;
    if (m_ier[0] && rx_ready)     return 4'h4;
    if (m_ier[1] && m_tf)         return 4'h2;
    return 4'h1;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_dll : rx_data;
      3'd1: return m_lcr[7] ? m_dlm : {4'h0, m_ier};
      3'd2: return {m_fifo, m_fifo, 2'b00, m_code()};
      3'd3: return m_lcr;
      3'd5: return m_lsr();
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_lcr = 0; m_dll = 0; m_dlm = 0; m_rdata = 0; m_txb = 0; m_ier = 0; m_err = 0;
    m_fifo = 0; m_e7 = 0; m_thre = 1; m_temt = 1; m_tf = 1; m_irq = 0; m_txl = 0; m_rxpop = 0;
  endtask

  task automatic model_step();
    logic dl, thrw, lsrrd, iirrd, ntf;
    logic [3:0] code, ev, nerr;
    logic [7:0] rv;
    dl    = m_lcr[7];
    thrw  = bus_wr && bus_addr == 0 && !dl;
    lsrrd = bus_rd && bus_addr == 5;
    iirrd = bus_rd && bus_addr == 2;
    code  = m_code();
    rv    = bus_rd ? m_read(bus_addr) : 8'h00;
    ev    = {ev_break, ev_framing, ev_parity, ev_overrun};
    if (thrw) ntf = 0;
    else if (ev_hold_empty || (bus_wr && bus_addr == 1 && !dl && bus_wdata[1] && !m_ier[1] && m_thre)) ntf = 1;
    else if (iirrd && code == 4'h2) ntf = 0;
    else ntf = m_tf;
    for (int i = 0; i < 4; i++) nerr[i] = ev[i] ? 1'b1 : (lsrrd ? 1'b0 : m_err[i]);
    m_irq   = (code != 4'h1);
    m_tf    = ntf;
    m_err   = nerr;
    m_e7    = ev_fifo_err ? 1'b1 : (lsrrd ? 1'b0 : m_e7);
    m_thre  = thrw ? 1'b0 : (ev_hold_empty ? 1'b1 : m_thre);
    m_temt  = thrw ? 1'b0 : (ev_shift_empty ? 1'b1 : m_temt);
    m_rdata = rv;
    m_txl   = thrw;
    m_rxpop = bus_rd && bus_addr == 0 && !dl;
    if (thrw) m_txb = bus_wdata;
    if (bus_wr) begin
      case (bus_addr)
        3'd0: if (dl) m_dll = bus_wdata;
        3'd1: if (dl) m_dlm = bus_wdata; else m_ier = bus_wdata[3:0];
        3'd2: m_fifo = bus_wdata[0];
        3'd3: m_lcr = bus_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    chk("R11 irq vs model", irq, m_irq);
    chk("R10 rd_data vs model", rd_data, m_rdata);
    chk("R2 tx_load vs model", tx_load, m_txl);
    chk("R2 tx_byte vs model", tx_byte, m_txb);
    chk("R10 rx_pop vs model", rx_pop, m_rxpop);
    chk("R1 divisor vs model", divisor, {m_dlm, m_dll});
    chk("R12 line_cfg vs model", line_cfg, m_lcr[6:0]);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    bus_wr = 0; bus_rd = 0;
    ev_hold_empty = 0; ev_shift_empty = 0; ev_overrun = 0; ev_parity = 0;
    ev_framing = 0; ev_break = 0; ev_fifo_err = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; cyc();
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1; cyc(); v = rd_data;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R3 irq after reset", irq, 0);
    rd(3'd5, v); chk("R2 LSR reset 0x60", v, 8'h60);

    // divisor access
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    chk("R1 no tx_load under DLAB", tx_load, 0);
    wr(3'd1, 8'h12);
    chk("R1 divisor output", divisor, 16'h1234);
    rd(3'd0, v); chk("R1 read DLL", v, 8'h34);
    rd(3'd1, v); chk("R1 read DLM", v, 8'h12);
    wr(3'd3, 8'h03);
    rd(3'd1, v); chk("R1 IER untouched by DLAB write", v, 8'h00);
    rd(3'd3, v); chk("R12 LCR readback", v, 8'h03);
    chk("R12 line_cfg", line_cfg, 7'h03);

    // FIFO mode, enable interrupts
    wr(3'd2, 8'h01);
    rd(3'd2, v); chk("R4 IIR none FIFO", v, 8'hC1);
    chk("R3 irq low before enable", irq, 0);
    wr(3'd1, 8'h07); cyc();
    chk("R3 enable raises irq", irq, 1);
    rd(3'd2, v); chk("R4 IIR holding-empty", v, 8'hC2);
    cyc(); chk("R7 IIR read clears irq", irq, 0);
    rd(3'd2, v); chk("R7 IIR none after clear", v, 8'hC1);

    // transmit write
    wr(3'd0, 8'h55);
    chk("R2 tx_load pulse", tx_load, 1);
    chk("R2 tx_byte", tx_byte, 8'h55);
    rd(3'd5, v); chk("R2 LSR after THR write", v, 8'h00);
    ev_hold_empty = 1; cyc(); cyc();
    chk("R7 hold-empty re-arms irq", irq, 1);
    rd(3'd5, v); chk("R2 holding-empty bit back", v, 8'h20);
    wr(3'd0, 8'h66); cyc();
    chk("R7 THR write clears irq", irq, 0);

    // line status gating
    wr(3'd1, 8'h04);
    ev_framing = 1; ev_fifo_err = 1; cyc(); cyc();
    chk("R6 line status irq", irq, 1);
    wr(3'd1, 8'h00); cyc();
    chk("R6 clear IER bit2 drops irq", irq, 0);
    wr(3'd1, 8'h04); cyc();
    chk("R6 restore IER bit2 raises irq", irq, 1);
    rx_ready = 1;
    wr(3'd1, 8'h05);
    rd(3'd2, v); chk("R4 line status outranks rx", v, 8'hC6);
    rd(3'd5, v); chk("R5 LSR 0x89", v, 8'h89);
    rd(3'd5, v); chk("R5 LSR cleared, DR stays", v, 8'h01);
    rd(3'd2, v); chk("R4 IIR rx data", v, 8'hC4);
    wr(3'd1, 8'h04); cyc();
    chk("R6 clear IER bit0 drops irq", irq, 0);
    wr(3'd1, 8'h05); cyc();
    chk("R6 restore IER bit0 raises irq", irq, 1);
    rx_data = 8'hA5;
    rd(3'd0, v); chk("R10 RBR data", v, 8'hA5);
    chk("R10 rx_pop", rx_pop, 1);

    // R8: lower-priority flag survives IIR reads
    wr(3'd1, 8'h07);
    ev_hold_empty = 1; ev_parity = 1; cyc();
    rd(3'd2, v); chk("R8 IIR line first", v, 8'hC6);
    rd(3'd5, v); chk("R5 parity bit", v, 8'h25);
    rd(3'd2, v); chk("R8 IIR rx second", v, 8'hC4);
    rx_ready = 0;
    rd(3'd2, v); chk("R8 holding-empty still armed", v, 8'hC2);
    rd(3'd2, v); chk("R7 cleared by own read", v, 8'hC1);

    // R9 same-cycle collisions
    ev_parity = 1; bus_addr = 3'd5; bus_rd = 1; cyc(); v = rd_data;
    chk("R9 read returns pre-event LSR", v[2], 0);
    rd(3'd5, v); chk("R9 parity survives coincident read", v[2], 1);
    ev_hold_empty = 1; cyc();
    ev_hold_empty = 1; bus_addr = 3'd2; bus_rd = 1; cyc(); v = rd_data;
    chk("R9 IIR reports holding-empty", v, 8'hC2);
    rd(3'd2, v); chk("R9 event keeps flag through IIR read", v, 8'hC2);
    rd(3'd2, v); chk("R7 flag cleared afterwards", v, 8'hC1);
    ev_hold_empty = 1; bus_addr = 3'd0; bus_wdata = 8'h77; bus_wr = 1; cyc();
    rd(3'd5, v); chk("R9 write wins over hold event", v[5], 0);
    ev_shift_empty = 1; cyc();
    rd(3'd5, v); chk("R2 shifter-empty bit", v[6], 1);

    // unmapped and idle read data
    rd(3'd6, v); chk("R10 unmapped reads zero", v, 8'h00);
    rd(3'd3, v); cyc();
    chk("R10 rd_data zero when idle", rd_data, 8'h00);

    // FIFO mode off
    wr(3'd2, 8'h00);
    rd(3'd2, v); chk("R4 IIR non-FIFO", v, 8'h01);
    wr(3'd1, 8'h00); cyc();
    chk("R11 irq low with nothing enabled", irq, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule